// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block is the host side of a single programmed-I/O transfer on a parallel ATA bus in True IDE mode. A request gives a transfer mode (0 to 6), a three-bit register address and a choice between the command and control register blocks. It also says whether the transfer is a read or a write, and whether it is a 16-bit data-port access or an 8-bit register access. The generator then runs three phases.

- **Setup.** It drives the address and chip selects, and for writes the data.
- **Strobe.** It asserts the read or write strobe for the mode's minimum active time. In modes 0 to 4 it holds the strobe longer while the device pulls the ready line low.
- **Recovery.** It waits out a recovery time chosen so that strobe-active plus recovery covers the mode's minimum cycle time.

On a read, the bus data is captured when the strobe is released. Every mode's timing is converted from nanoseconds to clock counts when the design is built, using the clock period parameter. The request side is a valid/ready port. `req_ready` is high only when the block is idle, so a request waits (valid held, fields stable) until the previous transfer's response has been taken.

The response side is a valid/ready port that appears only after recovery has finished. The response holds its data and timeout flag until `rsp_ready` is seen high. Holding `rsp_ready` low stalls the next request, but it never shortens any bus phase.

Top module: `ide_pio_timer`

In the requirements, T is the clock period (8 ns by default), and c(x) means x ns rounded up to whole clock cycles.

## Requirements
- R1: `req_ready` is 1 only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both 1, and no other request is taken until that request's response has been accepted.
- R2: From the cycle after acceptance until the response, the block drives the chip selects and the address, which stays stable while a strobe is low:
  - `ide_addr` equals the request address.
  - `ide_cs_n` is 2'b10 when `req_ctl_sel` is 0 (command block) and 2'b01 when it is 1 (control block).
  - In idle, `ide_cs_n` is 2'b11.
- R3: The strobe asserts exactly c(setup) cycles after the accepting edge. The setup is 70/50/30/30/25/15/10 ns for modes 0..6.
- R4: With the ready line high, the strobe of a 16-bit access stays low for exactly c(active16) cycles. active16 is 165/125/100/80/70/65/55 ns for modes 0..6.
- R5: An 8-bit access (`req_wide`=0) uses 290 ns of active time in modes 0, 1 and 2, and the 16-bit value in modes 3 to 6.
- R6: The response becomes valid R cycles after the strobe is released.
  - R is the largest of three terms: c(cycle) minus the unstretched active cycles, c(recovery floor), and c(write hold).
  - cycle is 600/383/240/180/120/100/80 ns for modes 0..6.
  - The recovery floor is 0/0/0/70/25/25/20 ns for modes 0..6.
  - The write hold is 30/20/15/10/10/10/5 ns for modes 0..6.
- R7: In modes 0 to 4, `ide_rdy` is sampled on each edge once the minimum active count is reached. The strobe is released on the first such edge that sees `ide_rdy` high.
- R8: In modes 0 to 4, if `ide_rdy` is still low when the strobe has been low for c(1285) cycles, the strobe is released on that edge. The response then carries `rsp_timeout`=1; otherwise `rsp_timeout` is 0.
- R9: In modes 5 and 6, `ide_rdy` has no effect: the strobe width is the R4/R5 value and `rsp_timeout` is 0.
- R10: A read asserts only `ide_rd_n`. `rsp_rdata` is the value of `ide_din` at the edge that releases the strobe, and later changes of `ide_din` do not alter it.
- R11: A write asserts only `ide_wr_n`. `ide_doe` is 1 and `ide_dout` equals the request data from setup through the end of recovery.
- R12: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_timeout` hold their values.
- R13: A mode value of 7 is timed as mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 3 | Transfer mode 0..6 (7 treated as 6) |
| req_addr | input | 3 | Register address |
| req_ctl_sel | input | 1 | 0 selects command block, 1 selects control block |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit data access, 0 for 8-bit register access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Transfer finished, response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read data captured at strobe release |
| rsp_timeout | output | 1 | Ready line exceeded its maximum low time |
| ide_addr | output | 3 | Bus address |
| ide_cs_n | output | 2 | Chip selects, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dout | output | 16 | Write data to bus |
| ide_doe | output | 1 | Bus data drive enable |
| ide_din | input | 16 | Read data from bus |
| ide_rdy | input | 1 | Device ready (wait when low) |

## Verification
Every result is timed from the accepting edge:
- The strobe falls c(setup) cycles after that edge.
- The strobe rises after the active count, or later by however long `ide_rdy` is held low.
- `rsp_valid` rises R cycles after the strobe rises.

The bench monitor counts these phases on falling clock edges, one count per cycle, and compares each count with the value the driver computed from the nanosecond tables. It drives `ide_rdy` low for a chosen number of strobe cycles, and changes `ide_din` right after release, to check which edge captures the data. With `rsp_ready` held low, it checks over several cycles that the response holds and no request is taken.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOVER,
    ST_RESP
  } pio_state_e;

  localparam int RDY_SAMPLE_NS = 35;
  localparam int RDY_MAX_LOW_NS = 1250;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // address valid before strobe
  function automatic int setup_ns(input int m);
    case (m)
      0: return 70;
      1: return 50;
      2: return 30;
      3: return 30;
      4: return 25;
      5: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int act16_ns(input int m);
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      4: return 70;
      5: return 65;
      default: return 55;
    endcase
  endfunction

  // byte-wide register accesses are slower in the three oldest modes
  function automatic int act8_ns(input int m);
    return (m <= 2) ? 290 : act16_ns(m);
  endfunction

  function automatic int cycle_ns(input int m);
    case (m)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      4: return 120;
      5: return 100;
      default: return 80;
    endcase
  endfunction

  // minimum strobe-inactive time, only defined for the faster modes
  function automatic int recov_ns(input int m);
    case (m)
      3: return 70;
      4: return 25;
      5: return 25;
      6: return 20;
      default: return 0;
    endcase
  endfunction

  function automatic int whold_ns(input int m);
    case (m)
      0: return 30;
      1: return 20;
      2: return 15;
      6: return 5;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
  import ide_pio_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int CNT_W  = 8
) (
  input  logic [2:0]       mode,
  input  logic             wide,
  output logic [CNT_W-1:0] setup_cyc,
  output logic [CNT_W-1:0] act_cyc,
  output logic [CNT_W-1:0] rec_cyc,
  output logic             rdy_used
);

  localparam int NSLOT = 8;

  logic [CNT_W-1:0] setup_tbl [NSLOT];
  logic [CNT_W-1:0] a16_tbl   [NSLOT];
  logic [CNT_W-1:0] a8_tbl    [NSLOT];
  logic [CNT_W-1:0] r16_tbl   [NSLOT];
  logic [CNT_W-1:0] r8_tbl    [NSLOT];
  logic [NSLOT-1:0] rdy_tbl;

  for (genvar m = 0; m < NSLOT; m++) begin : g_mode
    localparam int MM    = (m > 6) ? 6 : m;
    localparam int SC    = ns_to_cyc(setup_ns(MM), CLK_NS);
    localparam int A16   = ns_to_cyc(act16_ns(MM), CLK_NS);
    localparam int A8    = ns_to_cyc(act8_ns(MM), CLK_NS);
    localparam int T0    = ns_to_cyc(cycle_ns(MM), CLK_NS);
    localparam int FLOOR = max_int(ns_to_cyc(recov_ns(MM), CLK_NS),
                                   max_int(ns_to_cyc(whold_ns(MM), CLK_NS), 1));
    localparam int R16   = max_int(T0 - A16, FLOOR);
    localparam int R8    = max_int(T0 - A8, FLOOR);
    assign setup_tbl[m] = CNT_W'(SC);
    assign a16_tbl[m]   = CNT_W'(A16);
    assign a8_tbl[m]    = CNT_W'(A8);
    assign r16_tbl[m]   = CNT_W'(R16);
    assign r8_tbl[m]    = CNT_W'(R8);
    assign rdy_tbl[m]   = (MM < 5);
  end

  always_comb begin
    setup_cyc = setup_tbl[mode];
    act_cyc   = wide ? a16_tbl[mode] : a8_tbl[mode];
    rec_cyc   = wide ? r16_tbl[mode] : r8_tbl[mode];
    rdy_used  = rdy_tbl[mode];
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WAIT_LIM = 161
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic [CNT_W-1:0] act_cyc,
  input  logic [CNT_W-1:0] rec_cyc,
  input  logic             rdy_used,
  input  logic             ide_rdy,
  input  logic             rsp_ready,
  output logic             accept,
  output logic             strobe_on,
  output logic             bus_own,
  output logic             release_ev,
  output logic             timeout_ev,
  output logic             rsp_valid
);

  pio_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             min_done;
  logic             rdy_ok;
  logic             at_lim;

  assign min_done   = cnt_q >= (act_cyc - CNT_W'(1));
  assign rdy_ok     = !rdy_used || ide_rdy;
  assign at_lim     = cnt_q == CNT_W'(WAIT_LIM - 1);
  assign release_ev = (state_q == ST_ACTIVE) && min_done && (rdy_ok || at_lim);
  assign timeout_ev = release_ev && !rdy_ok;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign strobe_on = (state_q == ST_ACTIVE);
  assign bus_own   = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) ||
                     (state_q == ST_RECOVER);
  assign rsp_valid = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (req_valid) state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt_q == setup_cyc - CNT_W'(1)) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (release_ev) begin
            state_q <= ST_RECOVER;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RECOVER: begin
          if (cnt_q == rec_cyc - CNT_W'(1)) begin
            state_q <= ST_RESP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ctl_sel,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic [ADDR_W-1:0] ide_addr,
  output logic [1:0]        ide_cs_n,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [DATA_W-1:0] ide_dout,
  output logic              ide_doe,
  input  logic [DATA_W-1:0] ide_din,
  input  logic              ide_rdy
);

  localparam int WAIT_LIM = ns_to_cyc(RDY_SAMPLE_NS + RDY_MAX_LOW_NS, CLK_NS);
  localparam int CNT_W    = $clog2(WAIT_LIM + 1);

  logic [2:0]        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q;
  logic              wr_q;
  logic              wide_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tmo_q;

  logic [CNT_W-1:0]  setup_cyc;
  logic [CNT_W-1:0]  act_cyc;
  logic [CNT_W-1:0]  rec_cyc;
  logic              rdy_used;
  logic              accept;
  logic              strobe_on;
  logic              bus_own;
  logic              release_ev;
  logic              timeout_ev;

  ide_pio_timing #(
    .CLK_NS (CLK_NS),
    .CNT_W  (CNT_W)
  ) u_timing (
    .mode      (mode_q),
    .wide      (wide_q),
    .setup_cyc (setup_cyc),
    .act_cyc   (act_cyc),
    .rec_cyc   (rec_cyc),
    .rdy_used  (rdy_used)
  );

  ide_pio_seq #(
    .CNT_W    (CNT_W),
    .WAIT_LIM (WAIT_LIM)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .setup_cyc  (setup_cyc),
    .act_cyc    (act_cyc),
    .rec_cyc    (rec_cyc),
    .rdy_used   (rdy_used),
    .ide_rdy    (ide_rdy),
    .rsp_ready  (rsp_ready),
    .accept     (accept),
    .strobe_on  (strobe_on),
    .bus_own    (bus_own),
    .release_ev (release_ev),
    .timeout_ev (timeout_ev),
    .rsp_valid  (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b1;
      wdata_q <= '0;
      rdata_q <= '0;
      tmo_q   <= 1'b0;
    end else begin
      if (accept) begin
        mode_q  <= req_mode;
        addr_q  <= req_addr;
        sel_q   <= req_ctl_sel;
        wr_q    <= req_write;
        wide_q  <= req_wide;
        wdata_q <= req_wdata;
      end
      if (release_ev) begin
        tmo_q <= timeout_ev;
        if (!wr_q) rdata_q <= ide_din;
      end
    end
  end

  assign ide_addr    = addr_q;
  assign ide_cs_n    = !bus_own ? 2'b11 : (sel_q ? 2'b01 : 2'b10);
  assign ide_rd_n    = !(strobe_on && !wr_q);
  assign ide_wr_n    = !(strobe_on && wr_q);
  assign ide_dout    = wdata_q;
  assign ide_doe     = bus_own && wr_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = tmo_q;

endmodule

// File: rtl/ide_pio_chk.sv
module ide_pio_chk
  import ide_pio_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_mode,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_timeout,
  input logic [ADDR_W-1:0] ide_addr,
  input logic [1:0]        ide_cs_n,
  input logic              ide_rd_n,
  input logic              ide_wr_n,
  input logic              ide_doe
);

  localparam int LIM = ns_to_cyc(RDY_SAMPLE_NS + RDY_MAX_LOW_NS, CLK_NS);

  logic       strb;
  logic [2:0] mode_seen;
  int         low_run;

  assign strb = !ide_rd_n || !ide_wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_seen <= '0;
      low_run   <= 0;
    end else begin
      if (req_valid && req_ready) mode_seen <= req_mode;
      low_run <= strb ? low_run + 1 : 0;
    end
  end

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !req_ready);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout)));

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |-> ($stable(ide_addr) && $stable(ide_cs_n)));

  // R11
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_wr_n |-> ide_doe);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));

  // R8
  strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LIM);

  // R9
  fast_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && mode_seen >= 3'd5) |-> !rsp_timeout);

endmodule

bind ide_pio_timer ide_pio_chk #(
  .CLK_NS (CLK_NS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/ide_pio_timer_bench.sv
module ide_pio_timer_bench;

  localparam int CLK_NS = 8;
  localparam int LIM = (35 + 1250 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [2:0]  req_addr = '0;
  logic        req_ctl_sel = 1'b0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b1;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        rsp_timeout;
  logic [2:0]  ide_addr;
  logic [1:0]  ide_cs_n;
  logic        ide_rd_n;
  logic        ide_wr_n;
  logic [15:0] ide_dout;
  logic        ide_doe;
  logic [15:0] ide_din = '0;
  logic        ide_rdy = 1'b1;

  always #(CLK_NS/2) clk = ~clk;

  ide_pio_timer #(.CLK_NS(CLK_NS)) u_ide_pio_timer (.*);

  typedef struct {
    int          mode;
    bit          wide;
    bit          wr;
    bit          sel;
    int          addr;
    logic [15:0] wdata;
    logic [15:0] din;
    int          low;
    string       tag;
    int          es;
    int          ea;
    int          er;
    bit          eto;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  int seen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cy(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic item_t expect_of(input item_t it);
    int t1[7]  = '{70, 50, 30, 30, 25, 15, 10};
    int t2[7]  = '{165, 125, 100, 80, 70, 65, 55};
    int t0[7]  = '{600, 383, 240, 180, 120, 100, 80};
    int t2i[7] = '{0, 0, 0, 70, 25, 25, 20};
    int t4[7]  = '{30, 20, 15, 10, 10, 10, 5};
    int m = (it.mode > 6) ? 6 : it.mode;
    int amin = (!it.wide && m <= 2) ? cy(290) : cy(t2[m]);
    item_t r = it;
    r.es = cy(t1[m]);
    r.er = imax(cy(t0[m]) - amin, imax(cy(t2i[m]), cy(t4[m])));
    r.eto = 1'b0;
    if (m >= 5 || it.low == 0) r.ea = amin;
    else if (it.low >= LIM) begin
      r.ea = LIM;
      r.eto = 1'b1;
    end else r.ea = imax(amin, it.low + 1);
    return r;
  endfunction

  // monitor: phase counts on falling edges
  int    ph = 0;
  int    cs_cnt, ca_cnt, cr_cnt;
  item_t cur;

  always @(negedge clk) begin
    logic strb_n;
    logic other_n;
    strb_n  = cur.wr ? ide_wr_n : ide_rd_n;
    other_n = cur.wr ? ide_rd_n : ide_wr_n;
    case (ph)
      0: if (rst_n && req_valid && req_ready && q.size() > 0) begin
           cur = q.pop_front();
           ph = 1;
           cs_cnt = 0;
         end
      1: begin
           if (cs_cnt == 0) begin
             check(ide_addr == 3'(cur.addr), "R2", "address", ide_addr, cur.addr);
             check(ide_cs_n == (cur.sel ? 2'b01 : 2'b10), "R2", "chip selects",
                   ide_cs_n, cur.sel ? 1 : 2);
           end
           if ((cur.wr ? ide_wr_n : ide_rd_n) == 1'b1) cs_cnt++;
           else begin
             check(cs_cnt == cur.es, "R3", "setup cycles", cs_cnt, cur.es);
             check(other_n == 1'b1, cur.wr ? "R11" : "R10", "other strobe", other_n, 1);
             if (cur.wr)
               check(ide_doe && ide_dout == cur.wdata, "R11", "write data", ide_dout, cur.wdata);
             else
               check(!ide_doe, "R10", "no drive on read", ide_doe, 0);
             ca_cnt = 1;
             ide_rdy = (ca_cnt > cur.low);
             ph = 2;
           end
         end
      2: begin
           if (strb_n == 1'b0) begin
             ca_cnt++;
             ide_rdy = (ca_cnt > cur.low);
           end else begin
             check(ca_cnt == cur.ea, cur.tag, "strobe cycles", ca_cnt, cur.ea);
             ide_rdy = 1'b1;
             ide_din = ~cur.din;
             cr_cnt = 1;
             if (cur.wr)
               check(ide_doe && ide_dout == cur.wdata, "R11", "data in recovery",
                     ide_dout, cur.wdata);
             ph = 3;
           end
         end
      default: begin
           if (rsp_valid) begin
             check(cr_cnt == cur.er, "R6", "recovery cycles", cr_cnt, cur.er);
             check(rsp_timeout == cur.eto, (cur.mode >= 5) ? "R9" : "R8", "timeout flag",
                   rsp_timeout, cur.eto);
             if (!cur.wr)
               check(rsp_rdata == cur.din, "R10", "read data", rsp_rdata, cur.din);
             ph = 0;
             seen++;
           end else cr_cnt++;
         end
    endcase
  end

  task automatic run(input int mode, input bit wide, input bit wr, input bit sel,
                     input int addr, input logic [15:0] wdata, input logic [15:0] din,
                     input int low, input string tag, input int hold);
    item_t it;
    int target;
    it.mode = mode; it.wide = wide; it.wr = wr; it.sel = sel; it.addr = addr;
    it.wdata = wdata; it.din = din; it.low = low; it.tag = tag;
    it = expect_of(it);
    q.push_back(it);
    target = seen + 1;
    @(posedge clk); #2;
    req_mode = 3'(mode); req_wide = wide; req_write = wr; req_ctl_sel = sel;
    req_addr = 3'(addr); req_wdata = wdata; ide_din = din;
    rsp_ready = (hold == 0);
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    req_wdata = ~wdata;
    wait (seen == target);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(rsp_valid == 1'b1, "R12", "response held", rsp_valid, 1);
      check(rsp_rdata == din, "R12", "held data", rsp_rdata, din);
      check(req_ready == 1'b0, "R1", "no accept while response pending", req_ready, 0);
      @(posedge clk); #2;
      rsp_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R12", "response cleared", rsp_valid, 0);
      check(req_ready == 1'b1, "R1", "ready after response", req_ready, 1);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R12", "reset rsp_valid", rsp_valid, 0);
    check(ide_rd_n && ide_wr_n, "R10", "reset strobes", {ide_rd_n, ide_wr_n}, 3);
    check(ide_cs_n == 2'b11, "R2", "reset chip selects", ide_cs_n, 3);
    check(ide_doe == 1'b0, "R11", "reset drive", ide_doe, 0);

    run(0, 1, 0, 0, 3, 16'h0000, 16'h1234, 0, "R4", 0);
    run(0, 0, 1, 1, 5, 16'h00A5, 16'h0000, 0, "R5", 0);
    run(2, 0, 0, 0, 7, 16'h0000, 16'h00C3, 0, "R5", 0);
    run(4, 1, 1, 0, 0, 16'hBEEF, 16'h0000, 0, "R4", 0);
    run(3, 1, 0, 1, 6, 16'h0000, 16'h5A5A, 30, "R7", 0);
    run(2, 1, 0, 0, 1, 16'h0000, 16'h0F0F, 3, "R7", 0);
    run(1, 1, 0, 0, 2, 16'h0000, 16'h7777, 200, "R8", 0);
    run(5, 1, 0, 0, 4, 16'h0000, 16'h4321, 50, "R9", 0);
    run(7, 1, 1, 1, 2, 16'hC0DE, 16'h0000, 0, "R13", 0);
    run(6, 1, 0, 0, 3, 16'h0000, 16'h9AB1, 0, "R4", 5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", seen, 10);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule